// File: doc/BRIEF.md
# Graphics Command Stream Framer

The framer takes a stream of 32-bit command words on a valid/ready input and cuts it into whole command packets. The top byte of the first word of each packet is the opcode. A fixed per-opcode table, computed in logic, gives the number of extra words that follow it. When the last word of a packet arrives, the framer holds input off for one cycle to inspect the packet. It then either forwards the packet word by word on an output strobe or, for the two image-transfer opcodes, starts a rectangle transfer.

While it inspects a packet, the framer updates a 13-bit status field and eight 32-bit environment registers. It also keeps a sticky flag that records whether any drawing opcode has touched pixel memory. A write transfer puts the input into a raw mode: the next ceil(W·H/2) words go straight to a pixel port without opcode decoding, and then decoding resumes. If the input pauses partway through a packet, the words already received are kept until the rest arrive.

Top module: `cmdFramer`

## Requirements
- R1: Packet length is 1 + extra words. Opcodes 0x20–0x3F: extra = V·(1 + op[2] + op[4]) − op[4], where V = 4 if op[3] else 3 (0x20→3, 0x24→6, 0x2C→8, 0x3C→11). 0x40–0x5F: 0 if op[3:2]=01, else 2 + op[4] + op[3]. 0x60–0x7F: 2 + op[2] if op[4:3]=00, else 1 + op[2] (0x64→3, 0x68→1). 0x02→2, 0x80→3, 0xA0→2, 0xC0→2. All other opcodes → 0.
- R2: A non-transfer packet is sent out whole and in order, one word per cycle on outValid/outData. outLast is high only on its final word. inReady is low for every cycle in which outValid is high.
- R3: If input pauses partway through a packet (inValid low for any number of cycles), nothing is forwarded. The packet completes with the original words once the remaining words arrive.
- R4: For (op & 0xF4) = 0x24, statusBits[8:0] takes packet word 4 bits [8:0]. For (op & 0xF4) = 0x34, it takes word 5 bits [8:0]. Other status bits are unchanged.
- R5: Opcode 0xE1 loads statusBits[10:0] from its word bits [10:0]. Opcode 0xE6 loads statusBits[12:11] from its word bits [1:0].
- R6: Opcodes 0xE0–0xE7 store their whole word in environment register op[2:0], exposed as envRegs[32·k +: 32].
- R7: Opcode 0xA0 (write) or 0xC0 (read) pulses xferValid for one cycle, with xferIsRead = 1 for 0xC0. The fields are xferX = word1[9:0], xferY = word1[24:16] (9 bits), xferW = word2[15:0] and xferH = word2[31:16]. Transfer packets are not forwarded on outValid.
- R8: After a write transfer with W·H > 0, exactly ceil(W·H/2) input words appear unchanged on pixValid/pixData and are not decoded. Opcode decoding then resumes.
- R9: A read transfer, or a write transfer with W·H = 0, has no pixel phase. The next input word is decoded as an opcode.
- R10: pixDirty becomes 1 after any packet whose opcode lies in 0x02..0xBF and stays 1 until reset. Opcodes 0x00, 0x01 and 0xC0–0xFF leave it unchanged.
- R11: After reset, statusBits = 0, envRegs = 0, pixDirty = 0, inReady = 1, outValid = 0 and pixValid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word valid |
| inData | input | 32 | Input command or pixel word |
| inReady | output | 1 | Framer accepts a word this cycle |
| outValid | output | 1 | Forwarded packet word valid |
| outData | output | 32 | Forwarded packet word |
| outLast | output | 1 | Final word of the forwarded packet |
| pixValid | output | 1 | Raw pixel word valid during a write transfer |
| pixData | output | 32 | Raw pixel word (two pixels) |
| xferValid | output | 1 | One-cycle pulse: transfer started |
| xferIsRead | output | 1 | Started transfer is a read |
| xferX | output | 10 | Transfer rectangle X |
| xferY | output | 9 | Transfer rectangle Y |
| xferW | output | 16 | Transfer rectangle width |
| xferH | output | 16 | Transfer rectangle height |
| statusBits | output | 13 | Snooped status field |
| envRegs | output | 256 | Eight environment registers, register k at [32k+31:32k] |
| pixDirty | output | 1 | Sticky pixel-memory-touched flag |

## Verification
The hardest situation to reach is the change from raw pixel mode back to opcode decoding. An off-by-one in the word count there would either decode a pixel as an opcode or swallow the next command. The bench starts a write transfer with an odd pixel count (3×3, so five words), sends exactly that many pixel words, and then sends a normal packet. It checks that the pixel port saw five words and that the packet was forwarded intact. The held-partial-packet case is reached by stopping the input partway through a packet, waiting, and checking that nothing came out before the remaining words were sent.

// File: rtl/cmdFramerPkg.sv
package cmdFramerPkg;
  localparam int WordW     = 32;
  localparam int OpW       = 8;
  localparam int MaxPkt    = 12;
  localparam int CntW      = $clog2(MaxPkt + 1);
  localparam int EnvCount  = 8;
  localparam int StatusW   = 13;
  localparam int DimW      = 16;
  localparam int RemW      = 2 * DimW;

  typedef enum logic [1:0] {
    sCollect, sApply, sSend, sXfer
  } state_t;

  typedef struct packed {
    logic capture;
    logic apply;
    logic send;
    logic pixel;
  } strobe_t;

  typedef struct packed {
    logic pktDone;
    logic opWrite;
    logic opRead;
    logic xferZero;
    logic sendLast;
    logic pixLast;
  } hint_t;

  function automatic logic [CntW-1:0] extraWords(input logic [OpW-1:0] op);
    int e;
    int nv;
    e = 0;
    nv = op[3] ? 4 : 3;
    case (op[7:5])
      3'd0: e = (op == 8'h02) ? 2 : 0;
      3'd1: e = nv * (1 + int'(op[2]) + int'(op[4])) - int'(op[4]);
      3'd2: e = (op[3:2] == 2'b01) ? 0 : 2 + int'(op[4]) + int'(op[3]);
      3'd3: e = (op[4:3] == 2'b00) ? 2 + int'(op[2]) : 1 + int'(op[2]);
      3'd4: e = (op == 8'h80) ? 3 : 0;
      3'd5: e = (op == 8'hA0) ? 2 : 0;
      3'd6: e = (op == 8'hC0) ? 2 : 0;
      default: e = 0;
    endcase
    return CntW'(e);
  endfunction
endpackage

// File: rtl/cmdFramerCtrl.sv
module cmdFramerCtrl
  import cmdFramerPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  hint_t   hint,
  output strobe_t strobe,
  output logic    inReady,
  output logic    outValid
);
  state_t state, nextState;

  always_comb begin
    strobe.capture = (state == sCollect) && inValid;
    strobe.apply   = (state == sApply);
    strobe.send    = (state == sSend);
    strobe.pixel   = (state == sXfer) && inValid;
    inReady        = (state == sCollect) || (state == sXfer);
    outValid       = (state == sSend);
  end

  always_comb begin
    nextState = state;
    case (state)
      sCollect: if (strobe.capture && hint.pktDone) nextState = sApply;
      sApply: begin
        if (hint.opWrite && !hint.xferZero)  nextState = sXfer;
        else if (hint.opWrite || hint.opRead) nextState = sCollect;
        else                                  nextState = sSend;
      end
      sSend: if (hint.sendLast) nextState = sCollect;
      sXfer: if (strobe.pixel && hint.pixLast) nextState = sCollect;
      default: nextState = sCollect;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= sCollect;
    else       state <= nextState;
  end
endmodule

// File: rtl/cmdFramerData.sv
module cmdFramerData
  import cmdFramerPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WordW-1:0]         inData,
  input  strobe_t                  strobe,
  output hint_t                    hint,
  output logic [WordW-1:0]         outData,
  output logic                     outLast,
  output logic [WordW-1:0]         pixData,
  output logic                     xferValid,
  output logic                     xferIsRead,
  output logic [9:0]               xferX,
  output logic [8:0]               xferY,
  output logic [DimW-1:0]          xferW,
  output logic [DimW-1:0]          xferH,
  output logic [StatusW-1:0]       statusBits,
  output logic [EnvCount*WordW-1:0] envRegs,
  output logic                     pixDirty
);
  logic [WordW-1:0] pktBuf [MaxPkt];
  logic [WordW-1:0] envArr [EnvCount];
  logic [CntW-1:0]  cnt, lenReg, sendIdx, curLen;
  logic [OpW-1:0]   opReg, curOp;
  logic [RemW-1:0]  remWords, pixCount;

  assign curOp    = (cnt == '0) ? inData[WordW-1 -: OpW] : opReg;
  assign curLen   = extraWords(curOp) + CntW'(1);
  assign pixCount = pktBuf[2][DimW-1:0] * pktBuf[2][WordW-1:DimW];

  always_comb begin
    hint.pktDone  = (cnt == curLen - CntW'(1));
    hint.opWrite  = (opReg == 8'hA0);
    hint.opRead   = (opReg == 8'hC0);
    hint.xferZero = (pixCount == '0);
    hint.sendLast = (sendIdx == lenReg - CntW'(1));
    hint.pixLast  = (remWords == RemW'(1));
  end

  assign outData = pktBuf[sendIdx];
  assign outLast = strobe.send && hint.sendLast;
  assign pixData = inData;

  for (genvar k = 0; k < EnvCount; k++) begin : g_env
    assign envRegs[k*WordW +: WordW] = envArr[k];
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      pktBuf[cnt] <= inData;
      if (cnt == '0) begin
        opReg  <= curOp;
        lenReg <= curLen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      sendIdx    <= '0;
      remWords   <= '0;
      xferValid  <= 1'b0;
      xferIsRead <= 1'b0;
      xferX      <= '0;
      xferY      <= '0;
      xferW      <= '0;
      xferH      <= '0;
      statusBits <= '0;
      pixDirty   <= 1'b0;
      for (int k = 0; k < EnvCount; k++) envArr[k] <= '0;
    end else begin
      xferValid <= 1'b0;
      if (strobe.capture) cnt <= hint.pktDone ? '0 : cnt + CntW'(1);
      if (strobe.send)    sendIdx <= sendIdx + CntW'(1);
      if (strobe.pixel)   remWords <= remWords - RemW'(1);
      if (strobe.apply) begin
        sendIdx <= '0;
        if (opReg >= 8'h02 && opReg < 8'hC0) pixDirty <= 1'b1;
        if ((opReg & 8'hF4) == 8'h24) statusBits[8:0] <= pktBuf[4][8:0];
        if ((opReg & 8'hF4) == 8'h34) statusBits[8:0] <= pktBuf[5][8:0];
        if (opReg == 8'hE1) statusBits[10:0]  <= pktBuf[0][10:0];
        if (opReg == 8'hE6) statusBits[12:11] <= pktBuf[0][1:0];
        if (opReg[7:3] == 5'b11100) envArr[opReg[2:0]] <= pktBuf[0];
        if (hint.opWrite || hint.opRead) begin
          xferValid  <= 1'b1;
          xferIsRead <= hint.opRead;
          xferX      <= pktBuf[1][9:0];
          xferY      <= pktBuf[1][24:16];
          xferW      <= pktBuf[2][DimW-1:0];
          xferH      <= pktBuf[2][WordW-1:DimW];
          remWords   <= RemW'(pixCount[RemW-1:1]) + RemW'(pixCount[0]);
        end
      end
    end
  end
endmodule

// File: rtl/cmdFramer.sv
module cmdFramer
  import cmdFramerPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [31:0]               inData,
  output logic                      inReady,
  output logic                      outValid,
  output logic [31:0]               outData,
  output logic                      outLast,
  output logic                      pixValid,
  output logic [31:0]               pixData,
  output logic                      xferValid,
  output logic                      xferIsRead,
  output logic [9:0]                xferX,
  output logic [8:0]                xferY,
  output logic [15:0]               xferW,
  output logic [15:0]               xferH,
  output logic [12:0]               statusBits,
  output logic [255:0]              envRegs,
  output logic                      pixDirty
);
  strobe_t strobe;
  hint_t   hint;

  cmdFramerCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .hint(hint),
    .strobe(strobe), .inReady(inReady), .outValid(outValid)
  );

  cmdFramerData u_data (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe), .hint(hint),
    .outData(outData), .outLast(outLast), .pixData(pixData),
    .xferValid(xferValid), .xferIsRead(xferIsRead), .xferX(xferX),
    .xferY(xferY), .xferW(xferW), .xferH(xferH),
    .statusBits(statusBits), .envRegs(envRegs), .pixDirty(pixDirty)
  );

  assign pixValid = strobe.pixel;
endmodule

// File: rtl/cmdFramerChk.sv
module cmdFramerChk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outLast,
  input logic        pixValid,
  input logic        xferValid,
  input logic [12:0] statusBits,
  input logic        pixDirty
);
  p_ready_low_send_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
  p_last_in_pkt_r2: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> $stable(statusBits));
  p_pix_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (inValid && inReady && !outValid));
  p_xfer_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |=> !xferValid);
  p_xfer_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> !outValid);
  p_dirty_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixDirty |=> pixDirty);
endmodule

bind cmdFramer cmdFramerChk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outLast(outLast), .pixValid(pixValid),
  .xferValid(xferValid), .statusBits(statusBits), .pixDirty(pixDirty)
);

// File: tb/cmdFramer_tb.sv
module cmdFramer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic inReady, outValid, outLast, pixValid, xferValid, xferIsRead, pixDirty;
  logic [31:0] outData, pixData;
  logic [9:0] xferX;
  logic [8:0] xferY;
  logic [15:0] xferW, xferH;
  logic [12:0] statusBits;
  logic [255:0] envRegs;

  int nChecks = 0, nFails = 0;
  int outN = 0, pixN = 0, xferN = 0, overlapN = 0;
  logic [31:0] outArr [64];
  logic        lastArr [64];
  logic [31:0] pixArr [64];
  logic [31:0] pk [16];
  logic        xfRead;
  logic [9:0]  xfX;
  logic [8:0]  xfY;
  logic [15:0] xfW, xfH;

  always #10 clk = ~clk;

  cmdFramer u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outLast(outLast), .pixValid(pixValid), .pixData(pixData),
    .xferValid(xferValid), .xferIsRead(xferIsRead), .xferX(xferX),
    .xferY(xferY), .xferW(xferW), .xferH(xferH),
    .statusBits(statusBits), .envRegs(envRegs), .pixDirty(pixDirty)
  );

  always @(negedge clk) begin
    if (outValid && outN < 64) begin
      outArr[outN] = outData; lastArr[outN] = outLast; outN++;
    end
    if (outValid && inReady) overlapN++;
    if (pixValid && pixN < 64) begin pixArr[pixN] = pixData; pixN++; end
    if (xferValid) begin
      xferN++; xfRead = xferIsRead; xfX = xferX; xfY = xferY; xfW = xferW; xfH = xferH;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic putWord(input logic [31:0] w);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic putPk(input int first, input int n);
    for (int i = first; i < first + n; i++) putWord(pk[i]);
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic clearCap();
    outN = 0; pixN = 0; xferN = 0;
  endtask

  task automatic checkFwd(input string req, input int n);
    check(req, 64'(outN), 64'(n));
    for (int i = 0; i < n; i++) begin
      check(req, 64'(outArr[i]), 64'(pk[i]));
      check(req, 64'(lastArr[i]), 64'(i == n - 1));
    end
  endtask

  task automatic testReset();
    check("R11 status", 64'(statusBits), 64'h0);
    check("R11 env", 64'(|envRegs), 64'h0);
    check("R11 dirty", 64'(pixDirty), 64'h0);
    check("R11 ready", 64'(inReady), 64'h1);
    check("R11 outValid", 64'(outValid), 64'h0);
    check("R11 pixValid", 64'(pixValid), 64'h0);
  endtask

  task automatic testNoDirtyEnv();
    clearCap();
    pk[0] = 32'h0000_0000; putPk(0, 1); settle();
    checkFwd("R1 op00 len1", 1);
    clearCap();
    pk[0] = 32'h01AB_CDEF; putPk(0, 1); settle();
    checkFwd("R1 op01 len1", 1);
    clearCap();
    pk[0] = 32'hE512_3456; putPk(0, 1); settle();
    checkFwd("R6 forward E5", 1);
    check("R6 env5", 64'(envRegs[5*32 +: 32]), 64'hE512_3456);
    check("R6 env4 untouched", 64'(envRegs[4*32 +: 32]), 64'h0);
    check("R10 no dirty for 00/01/E5", 64'(pixDirty), 64'h0);
  endtask

  task automatic testLengths();
    clearCap();
    pk[0] = 32'h2011_1111; pk[1] = 32'h1; pk[2] = 32'h2; pk[3] = 32'h3;
    putPk(0, 4); settle();
    checkFwd("R1 op20 len4", 4);
    check("R10 dirty after 20", 64'(pixDirty), 64'h1);
    check("R2 ready low while forwarding", 64'(overlapN), 64'h0);
    clearCap();
    pk[0] = 32'h3C00_0000;
    for (int i = 1; i < 12; i++) pk[i] = 32'(i * 7);
    putPk(0, 12); settle();
    checkFwd("R1 op3C len12", 12);
    clearCap();
    pk[0] = 32'h6400_0000; pk[1] = 32'hA; pk[2] = 32'hB; pk[3] = 32'hC;
    putPk(0, 4); settle();
    checkFwd("R1 op64 len4", 4);
    clearCap();
    pk[0] = 32'h6800_0000; pk[1] = 32'hD;
    putPk(0, 2); settle();
    checkFwd("R1 op68 len2", 2);
  endtask

  task automatic testPartial();
    clearCap();
    pk[0] = 32'h2800_0005; pk[1] = 32'h11; pk[2] = 32'h22; pk[3] = 32'h33; pk[4] = 32'h44;
    putPk(0, 2); settle();
    check("R3 held no output", 64'(outN), 64'h0);
    putPk(2, 3); settle();
    checkFwd("R3 completed later", 5);
  endtask

  task automatic testSnoop();
    clearCap();
    pk[0] = 32'hE100_05AB; putPk(0, 1); settle();
    check("R5 E1 status", 64'(statusBits), 64'h05AB);
    pk[0] = 32'hE600_0003; putPk(0, 1); settle();
    check("R5 E6 status", 64'(statusBits), 64'h1DAB);
    pk[0] = 32'h2400_0000;
    for (int i = 1; i < 7; i++) pk[i] = 32'hFFFF_FE00;
    pk[4] = 32'hFFFF_FFA5;
    putPk(0, 7); settle();
    check("R4 op24 word4", 64'(statusBits), 64'h1DA5);
    pk[0] = 32'h3600_0000;
    for (int i = 1; i < 9; i++) pk[i] = 32'h0000_01FF;
    pk[5] = 32'hABCD_0077;
    putPk(0, 9); settle();
    check("R4 op36 word5", 64'(statusBits), 64'h1C77);
  endtask

  task automatic testWriteXfer();
    clearCap();
    pk[0] = 32'hA000_0000; pk[1] = 32'hFFFF_0123; pk[2] = 32'h0003_0003;
    putPk(0, 3); settle();
    check("R7 pulse count", 64'(xferN), 64'h1);
    check("R7 is write", 64'(xfRead), 64'h0);
    check("R7 X", 64'(xfX), 64'h123);
    check("R7 Y masked", 64'(xfY), 64'h1FF);
    check("R7 W", 64'(xfW), 64'h3);
    check("R7 H", 64'(xfH), 64'h3);
    check("R7 not forwarded", 64'(outN), 64'h0);
    for (int i = 0; i < 5; i++) pk[i] = 32'hC0DE_0000 + 32'(i);
    putPk(0, 5); settle();
    check("R8 pixel word count", 64'(pixN), 64'h5);
    for (int i = 0; i < 5; i++) check("R8 pixel data", 64'(pixArr[i]), 64'(pk[i]));
    check("R8 pixels not forwarded", 64'(outN), 64'h0);
    pk[0] = 32'h2000_0000; pk[1] = 32'h5; pk[2] = 32'h6; pk[3] = 32'h7;
    putPk(0, 4); settle();
    checkFwd("R8 decode resumes", 4);
    check("R8 no extra pixels", 64'(pixN), 64'h5);
  endtask

  task automatic testReadAndZero();
    clearCap();
    pk[0] = 32'hC000_0000; pk[1] = 32'h0010_0020; pk[2] = 32'h0002_0004;
    putPk(0, 3); settle();
    check("R9 read pulse", 64'(xferN), 64'h1);
    check("R9 read flag", 64'(xfRead), 64'h1);
    pk[0] = 32'h2000_0000; pk[1] = 32'h1; pk[2] = 32'h2; pk[3] = 32'h3;
    putPk(0, 4); settle();
    checkFwd("R9 read no pixel phase", 4);
    check("R9 read no pixels", 64'(pixN), 64'h0);
    clearCap();
    pk[0] = 32'hA000_0000; pk[1] = 32'h0; pk[2] = 32'h0005_0000;
    putPk(0, 3); settle();
    check("R9 zero write pulse", 64'(xferN), 64'h1);
    pk[0] = 32'h2000_0000; pk[1] = 32'h9; pk[2] = 32'h8; pk[3] = 32'h7;
    putPk(0, 4); settle();
    checkFwd("R9 zero write no pixel phase", 4);
    check("R9 zero write no pixels", 64'(pixN), 64'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoDirtyEnv();
    testLengths();
    testPartial();
    testSnoop();
    testWriteXfer();
    testReadAndZero();
    check("R2 ready low while forwarding", 64'(overlapN), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule